// File: doc/BRIEF.md
# Programmable Binary Phase-Code Correlator

This block is a streaming matched filter for radar returns whose transmitted pulse was split into sub-pulses and phase-flipped by a binary code. Every clock it takes one signed digitized sample into a tap delay line. It weights each tap by +1 or -1 according to a programmable code bit, and drops taps that a programmable enable mask turns off. The weighted taps are summed by a carry-save reduction tree followed by one carry-propagate adder. One correlation value comes out for every sample.

The code and the mask are written in parallel whenever the load strobe is high. A code shorter than the line, such as any Barker code, uses the low taps with the remaining mask bits cleared. Negation is approximated by a bitwise complement (-x-1), which saves one increment per tap. The result is the upper part of a full-precision sum.

Top module: `pcode_correlator`

## Requirements
- R1: While rst_ni is low, and after it is released until a code and mask are loaded, corr_o is 0. Reset clears the delay line, the code register and the mask register.
- R2: Tap j holds the sample that was presented j clock edges before the sample held in tap 0. Tap 0 holds the most recent sample.
- R3: A code bit of 1 passes its tap's two's-complement sample unchanged. A code bit of 0 replaces the sample with its bitwise complement, which equals -x-1.
- R4: A mask bit of 1 enables its tap. A mask bit of 0 makes the tap contribute zero, whatever the code bit.
- R5: code_i and mask_i are captured at a clock edge where load_i is 1. When load_i is 0 the stored code and mask do not change, whatever code_i and mask_i do.
- R6: The weighted taps are summed without loss as a 16-bit two's-complement value. corr_o carries bits 15..2 of that sum.
- R7: A sample presented at clock edge k affects corr_o from just after edge k+1. A code or mask loaded at edge k also affects corr_o from edge k+1.
- R8: A new correlation value is produced on every clock, with no stall between results.
- R9: A 13-chip Barker code (transmitted 1111100110101, first chip leftmost) is loaded reversed into code bits 12..0, with mask 0x1FFF. Fed the matching ±512 chip sequence, the filter gives a peak of 1663 one edge after the last chip.
- R10: Full-scale inputs do not overflow. Sixteen samples of -2048 with every code bit at 1 give -8192. With every code bit at 0 they give 8188.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 12 | Signed sample entering tap 0 |
| load_i | input | 1 | Load strobe for code_i and mask_i |
| code_i | input | 16 | Per-tap sign code, bit j for tap j |
| mask_i | input | 16 | Per-tap enable, bit j for tap j |
| corr_o | output | 14 | Registered correlation, sum bits 15..2 |

## Verification
The checker tests four things on every cycle. It checks that the delay line advances by exactly one stage. It checks that the code and mask registers capture on a load and hold otherwise. It checks that an all-zero mask forces a zero result on the next edge. The arithmetic is left to the bench scenarios, which compare every output cycle against a reference correlation: complement weighting, mask selection, truncation of the sum, the two-edge latency, the Barker peak and the full-scale extremes.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  // operand count after one 3:2 level
  function automatic int csa_next(input int n);
    return 2 * (n / 3) + (n % 3);
  endfunction

  function automatic int csa_count(input int n, input int lvl);
    int c;
    c = n;
    for (int i = 0; i < lvl; i++) c = csa_next(c);
    return c;
  endfunction

  function automatic int csa_levels(input int n);
    int c;
    int l;
    c = n;
    l = 0;
    while (c > 2) begin
      c = csa_next(c);
      l++;
    end
    return l;
  endfunction
endpackage

// File: rtl/pcc_tap_line.sv
module pcc_tap_line #(
  parameter int W = 12,
  parameter int N = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [W-1:0]        sample_i,
  output logic [N-1:0][W-1:0] taps_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) taps_o <= '0;
    else         taps_o <= {taps_o[N-2:0], sample_i};
  end
endmodule

// File: rtl/pcc_tap_weight.sv
module pcc_tap_weight #(
  parameter int W     = 12,
  parameter int ACC_W = 16,
  parameter int N     = 16
) (
  input  logic [N-1:0][W-1:0]     taps_i,
  input  logic [N-1:0]            code_i,
  input  logic [N-1:0]            mask_i,
  output logic [N-1:0][ACC_W-1:0] ops_o
);
  for (genvar j = 0; j < N; j++) begin : g_tap
    logic [W-1:0] v;
    // xnor with code bit: complement when code is 0
    assign v = taps_i[j] ^ {W{~code_i[j]}};
    assign ops_o[j] = mask_i[j] ? {{(ACC_W-W){v[W-1]}}, v} : '0;
  end
endmodule

// File: rtl/pcc_csa.sv
module pcc_csa #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] cy_o
);
  logic [W-1:0] maj;
  assign sum_o = a_i ^ b_i ^ c_i;
  assign maj   = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
  assign cy_o  = {maj[W-2:0], 1'b0};
endmodule

// File: rtl/pcc_csa_tree.sv
module pcc_csa_tree
  import pcc_pkg::*;
#(
  parameter int W = 16,
  parameter int N = 16
) (
  input  logic [N-1:0][W-1:0] ops_i,
  output logic [W-1:0]        sum_o
);
  localparam int LVLS = csa_levels(N);

  logic [W-1:0] lv [LVLS+1][N];

  for (genvar k = 0; k < N; k++) begin : g_in
    assign lv[0][k] = ops_i[k];
  end

  for (genvar l = 0; l < LVLS; l++) begin : g_lvl
    localparam int NC = csa_count(N, l);
    localparam int NX = csa_count(N, l + 1);
    localparam int G  = NC / 3;
    localparam int R  = NC % 3;
    for (genvar g = 0; g < G; g++) begin : g_csa
      pcc_csa #(.W(W)) u_csa (
        .a_i  (lv[l][3*g]),
        .b_i  (lv[l][3*g+1]),
        .c_i  (lv[l][3*g+2]),
        .sum_o(lv[l+1][2*g]),
        .cy_o (lv[l+1][2*g+1])
      );
    end
    for (genvar r = 0; r < R; r++) begin : g_pass
      assign lv[l+1][2*G+r] = lv[l][3*G+r];
    end
    for (genvar k = NX; k < N; k++) begin : g_zero
      assign lv[l+1][k] = '0;
    end
  end

  // single carry-propagate adder
  assign sum_o = lv[LVLS][0] + lv[LVLS][1];
endmodule

// File: rtl/pcode_correlator.sv
module pcode_correlator #(
  parameter int SAMPLE_W = 12,
  parameter int TAPS     = 16,
  parameter int OUT_W    = 14
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                load_i,
  input  logic [TAPS-1:0]     code_i,
  input  logic [TAPS-1:0]     mask_i,
  output logic [OUT_W-1:0]    corr_o
);
  localparam int ACC_W = SAMPLE_W + $clog2(TAPS);

  logic [TAPS-1:0]                 code_q;
  logic [TAPS-1:0]                 mask_q;
  logic [TAPS-1:0][SAMPLE_W-1:0]   taps;
  logic [TAPS-1:0][ACC_W-1:0]      ops;
  logic [ACC_W-1:0]                acc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      mask_q <= '0;
    end else if (load_i) begin
      code_q <= code_i;
      mask_q <= mask_i;
    end
  end

  pcc_tap_line #(.W(SAMPLE_W), .N(TAPS)) u_line (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sample_i(sample_i),
    .taps_o  (taps)
  );

  pcc_tap_weight #(.W(SAMPLE_W), .ACC_W(ACC_W), .N(TAPS)) u_weight (
    .taps_i(taps),
    .code_i(code_q),
    .mask_i(mask_q),
    .ops_o (ops)
  );

  pcc_csa_tree #(.W(ACC_W), .N(TAPS)) u_tree (
    .ops_i(ops),
    .sum_o(acc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) corr_o <= '0;
    else         corr_o <= acc[ACC_W-1 -: OUT_W];
  end
endmodule

// File: rtl/pcode_correlator_chk.sv
module pcode_correlator_chk #(
  parameter int SAMPLE_W = 12,
  parameter int TAPS     = 16,
  parameter int OUT_W    = 14
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          load_i,
  input logic [TAPS-1:0]               code_i,
  input logic [TAPS-1:0]               mask_i,
  input logic [TAPS-1:0]               code_q,
  input logic [TAPS-1:0]               mask_q,
  input logic [TAPS-1:0][SAMPLE_W-1:0] taps,
  input logic [OUT_W-1:0]              corr_o
);
  a_r2_shift_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> taps[TAPS-1:1] == $past(taps[TAPS-2:0]));

  a_r5_load_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (code_q == $past(code_i)) && (mask_q == $past(mask_i)));

  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(code_q) && $stable(mask_q));

  a_r4_mask_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |=> (corr_o == '0));
endmodule

bind pcode_correlator pcode_correlator_chk #(
  .SAMPLE_W(SAMPLE_W), .TAPS(TAPS), .OUT_W(OUT_W)
) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .load_i(load_i),
  .code_i(code_i),
  .mask_i(mask_i),
  .code_q(code_q),
  .mask_q(mask_q),
  .taps  (taps),
  .corr_o(corr_o)
);

// File: tb/tb_pcode_correlator.sv
module tb_pcode_correlator;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 12;
  localparam int NT = 16;
  localparam int OW = 14;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [SW-1:0] sample_i = '0;
  logic          load_i = 1'b0;
  logic [NT-1:0] code_i = '0;
  logic [NT-1:0] mask_i = '0;
  logic [OW-1:0] corr_o;

  int checks = 0;
  int fails = 0;
  int m_taps [NT];
  logic [NT-1:0] m_code = '0;
  logic [NT-1:0] m_mask = '0;
  logic [OW-1:0] last_out;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pcode_correlator #(.SAMPLE_W(SW), .TAPS(NT), .OUT_W(OW)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sample_i(sample_i), .load_i(load_i),
    .code_i(code_i), .mask_i(mask_i), .corr_o(corr_o)
  );

  function automatic logic [OW-1:0] ref_corr();
    int acc = 0;
    logic [15:0] a16;
    for (int j = 0; j < NT; j++)
      if (m_mask[j]) acc += m_code[j] ? m_taps[j] : -m_taps[j] - 1;
    a16 = acc[15:0];
    return a16[15:2];
  endfunction

  task automatic check(input string req, input logic [OW-1:0] act, input logic [OW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, $signed(act), $signed(exp));
    end
  endtask

  // entered and left at a negedge
  task automatic step(input logic [SW-1:0] s, input logic ld, input logic [NT-1:0] c,
                      input logic [NT-1:0] m, input string req);
    logic [OW-1:0] exp;
    sample_i = s; load_i = ld; code_i = c; mask_i = m;
    @(posedge clk_i);
    exp = ref_corr();
    for (int j = NT - 1; j > 0; j--) m_taps[j] = m_taps[j-1];
    m_taps[0] = int'($signed(s));
    if (ld) begin m_code = c; m_mask = m; end
    @(negedge clk_i);
    last_out = corr_o;
    check(req, corr_o, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [12:0] barker;
    logic [NT-1:0] bcode;
    void'($urandom(32'd20240611));
    for (int j = 0; j < NT; j++) m_taps[j] = 0;
    sample_i = 12'h5A5;
    repeat (3) @(negedge clk_i);
    check("R1 reset", corr_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after reset", corr_o, '0);
    // R1: nothing loaded yet, samples must not show
    for (int i = 0; i < 6; i++) step(12'($urandom), 1'b0, '1, '1, "R1_unloaded");

    // R7/R2: single impulse through one enabled tap
    step(12'h000, 1'b1, '1, 16'h0020, "R7_load");
    step(12'h400, 1'b0, '0, '0, "R2_impulse");
    for (int i = 0; i < 8; i++) step(12'h000, 1'b0, '0, '0, "R2_R7_delay");

    // R3: alternating code, all taps
    step(12'h123, 1'b1, 16'hAAAA, '1, "R3_load");
    for (int i = 0; i < 20; i++) step(12'($urandom), 1'b0, '0, '0, "R3_alt_code");

    // R4: sparse mask, code bits under masked taps vary
    step(12'h7FF, 1'b1, 16'h5A3C, 16'h0F0F, "R4_load");
    for (int i = 0; i < 20; i++) step(12'($urandom), 1'b0, '0, '0, "R4_mask");

    // R5: code_i/mask_i toggle with load low
    for (int i = 0; i < 10; i++)
      step(12'($urandom), 1'b0, 16'($urandom), 16'($urandom), "R5_hold");

    // R10: full-scale negative, code all 1 then all 0
    step(12'h800, 1'b1, '1, '1, "R10_load");
    for (int i = 0; i < NT; i++) step(12'h800, 1'b0, '0, '0, "R10_fill");
    check("R10 min", last_out, 14'h2000);
    step(12'h800, 1'b1, '0, '1, "R10_load0");
    step(12'h800, 1'b0, '0, '0, "R10_comp");
    check("R10 max", last_out, 14'd8188);

    // R9: Barker 13 matched filter
    barker = 13'b1111100110101;
    bcode = '0;
    for (int j = 0; j < 13; j++) bcode[j] = barker[j];
    step(12'h000, 1'b1, bcode, 16'h1FFF, "R9_load");
    for (int i = 0; i < 13; i++)
      step(barker[12-i] ? 12'd512 : -12'sd512, 1'b0, '0, '0, "R9_chips");
    step(12'h000, 1'b0, '0, '0, "R9_next");
    check("R9 peak", last_out, 14'd1663);

    // R6/R8: random code/mask reloads mixed with continuous samples
    for (int i = 0; i < 300; i++)
      step(12'($urandom), ($urandom % 8) == 0, 16'($urandom), 16'($urandom), "R6_R8_random");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule